// File: doc/BRIEF.md
# UART Queue Level and Receive Error Interrupt Controller

This block holds the interrupt and error-status logic that sits beside the receive and transmit queues of a UART. It watches the two occupancy counts and compares each against a programmable threshold given in eighths of the queue depth. When a count crosses its threshold, it latches a receive-level or transmit-level interrupt. It also gathers per-character receiver error strobes, a receive-timeout event and a clear-to-send change event into one raw interrupt vector. A mask register gates that vector into a masked vector and one combined interrupt line. A four-bit receiver error status runs alongside and has its own clear.

The queues, the serial shifter and the bus decode are outside this block. Registers are written through a plain write strobe, a 2-bit select and a data byte. Every pin is a plain control or status pin. There is no stream interface and no back-pressure. Select encoding: 0 = level register, 1 = mask register, 2 = interrupt clear, 3 = error clear.

Raw vector bit order: 0 receive level, 1 transmit level, 2 receive timeout, 3 framing, 4 parity, 5 break, 6 overrun, 7 clear-to-send change.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, raw status, masked status, error status and the interrupt line are all zero. The mask register resets to zero. The level register resets to code 2 in both fields.
- R2: In the level register, write-data bits [2:0] hold the transmit code and bits [5:3] hold the receive code. Codes 0, 1, 2, 3 and 4 give thresholds of 1/8, 2/8, 4/8, 6/8 and 7/8 of DEPTH. Codes 5 to 7 give 4/8. For DEPTH 32 the thresholds are 4, 8, 16, 24, 28 and 16.
- R3: Raw bit 0 is set one cycle after a clock edge at which the receive count is at or above its threshold, when it was below the threshold at the previous edge.
- R4: Raw bit 1 is set one cycle after an edge at which the transmit count is at or below its threshold, when it was above the threshold at the previous edge. The empty queue present at reset counts as already met, so no event is raised for it.
- R5: Once set, a level bit stays set when the count moves back across the threshold or the level code changes. Only a clear write removes it.
- R6: A push with flags rx_push_err (bit0 framing, bit1 parity, bit2 break) sets raw bits 3, 4 and 5 one cycle later. rto_evt sets raw bit 2 and cts_evt sets raw bit 7.
- R7: A push while the receive count equals DEPTH sets raw bit 6 and error bit 3 (overrun) on the next cycle, without waiting for a read.
- R8: On a pop, error bits [2:0] (bit0 framing, bit1 parity, bit2 break) are loaded from rx_pop_err, which are the flags of the character being read.
- R9: Any write to the error-clear select clears all four error bits and leaves the raw vector unchanged.
- R10: Writing the interrupt-clear select clears each raw bit whose data bit is one, and zeros have no effect. A source event in the same cycle wins over the clear.
- R11: The masked status is raw AND mask, and irq is the OR of the masked bits. Both follow a mask write on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | CNT_W | Receive queue occupancy |
| tx_count | input | CNT_W | Transmit queue occupancy |
| rx_push | input | 1 | A received character enters the queue this cycle |
| rx_push_err | input | 3 | Error flags of the arriving character |
| rx_pop | input | 1 | A character is read from the receive queue |
| rx_pop_err | input | 3 | Error flags of the character being read |
| rto_evt | input | 1 | Receive timeout event strobe |
| cts_evt | input | 1 | Clear-to-send change event strobe |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| raw_stat | output | 8 | Raw interrupt status |
| mask_stat | output | 8 | Masked interrupt status |
| irq | output | 1 | Combined interrupt |
| err_stat | output | 4 | Receiver error status: framing, parity, break, overrun |

## Verification
The bench first drives the count one below and then exactly at each threshold, because a design with an off-by-one comparison would either raise the level bit one character early or miss the crossing. It moves the counts back after a level bit has been set, to catch a design that tracks the level rather than latching it. It also checks that the reset-time empty transmit queue raises no interrupt. Overrun is forced with a full queue before any read, so a design that defers overrun to read time leaves the error bit clear. A clear and an event are written in the same cycle, where a design that lets the clear win would lose the event.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 8;

  localparam int SRC_RXLVL = 0;
  localparam int SRC_TXLVL = 1;
  localparam int SRC_RTO   = 2;
  localparam int SRC_FRM   = 3;
  localparam int SRC_PAR   = 4;
  localparam int SRC_BRK   = 5;
  localparam int SRC_OVR   = 6;
  localparam int SRC_CTS   = 7;

  typedef enum logic [1:0] {
    SEL_LEVEL = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_ICLR  = 2'd2,
    SEL_ECLR  = 2'd3
  } reg_sel_e;

  // threshold code -> number of eighths of the queue depth
  function automatic logic [2:0] code_to_eighths(input logic [2:0] code);
    case (code)
      3'd0:    return 3'd1;
      3'd1:    return 3'd2;
      3'd2:    return 3'd4;
      3'd3:    return 3'd6;
      3'd4:    return 3'd7;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_lvl.sv
module uart_irq_lvl
  import uart_irq_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter bit AT_OR_ABOVE = 1'b1,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [2:0]       code,
  output logic             evt
);
  localparam int TW = CNT_W + 3;

  logic [TW-1:0]    thr_x8;
  logic [CNT_W-1:0] thr;
  logic             cond;
  logic             cond_q;

  always_comb begin
    thr_x8 = TW'(DEPTH) * TW'(code_to_eighths(code));
    thr    = thr_x8[TW-1:3];
  end

  generate
    if (AT_OR_ABOVE) begin : g_fill
      assign cond = (count >= thr);
    end else begin : g_drain
      assign cond = (count <= thr);
    end
  endgenerate

  // the reset state is an empty queue: met for drain, not met for fill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= !AT_OR_ABOVE;
    else        cond_q <= cond;
  end

  assign evt = cond && !cond_q;
endmodule

// File: rtl/uart_irq_err.sv
module uart_irq_err (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       full,
  input  logic       pop,
  input  logic [2:0] pop_err,
  input  logic       clr_all,
  output logic       ovr_evt,
  output logic [3:0] err_stat
);
  assign ovr_evt = push && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_stat <= '0;
    end else begin
      if (clr_all) err_stat      <= '0;
      if (pop)     err_stat[2:0] <= pop_err;
      if (ovr_evt) err_stat[3]   <= 1'b1;
    end
  end

  // R7
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> err_stat[3]);

  // R9
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !pop && !(push && full)) |=> (err_stat == 4'b0));
endmodule

// File: rtl/uart_irq_stat.sv
module uart_irq_stat #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] raw,
  output logic [N-1:0] masked,
  output logic         irq
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw    <= '0;
      mask_q <= '0;
    end else begin
      raw <= (raw & ~clr_vec) | set_vec;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign masked = raw & mask_q;
  assign irq    = |masked;

  // R10
  int_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((raw & $past(clr_vec & ~set_vec)) == '0));

  // R5
  lvl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[0] && !clr_vec[0]) |=> raw[0]);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DEPTH   = 32,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic [CNT_W-1:0]   tx_count,
  input  logic               rx_push,
  input  logic [2:0]         rx_push_err,
  input  logic               rx_pop,
  input  logic [2:0]         rx_pop_err,
  input  logic               rto_evt,
  input  logic               cts_evt,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [7:0]         reg_wdata,
  output logic [NUM_SRC-1:0] raw_stat,
  output logic [NUM_SRC-1:0] mask_stat,
  output logic               irq,
  output logic [3:0]         err_stat
);
  logic [5:0]         level_q;
  logic               rx_lvl_evt;
  logic               tx_lvl_evt;
  logic               ovr_evt;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic               wr_level;
  logic               wr_mask;
  logic               wr_iclr;
  logic               wr_eclr;

  assign wr_level = reg_we && (reg_sel == SEL_LEVEL);
  assign wr_mask  = reg_we && (reg_sel == SEL_MASK);
  assign wr_iclr  = reg_we && (reg_sel == SEL_ICLR);
  assign wr_eclr  = reg_we && (reg_sel == SEL_ECLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level_q <= {3'd2, 3'd2};
    else if (wr_level) level_q <= reg_wdata[5:0];
  end

  uart_irq_lvl #(.DEPTH(DEPTH), .AT_OR_ABOVE(1'b1)) u_rx_lvl (
    .clk(clk), .rst_n(rst_n), .count(rx_count), .code(level_q[5:3]), .evt(rx_lvl_evt)
  );

  uart_irq_lvl #(.DEPTH(DEPTH), .AT_OR_ABOVE(1'b0)) u_tx_lvl (
    .clk(clk), .rst_n(rst_n), .count(tx_count), .code(level_q[2:0]), .evt(tx_lvl_evt)
  );

  uart_irq_err u_err (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .full(rx_count == CNT_W'(DEPTH)),
    .pop(rx_pop), .pop_err(rx_pop_err), .clr_all(wr_eclr),
    .ovr_evt(ovr_evt), .err_stat(err_stat)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[SRC_RXLVL] = rx_lvl_evt;
    set_vec[SRC_TXLVL] = tx_lvl_evt;
    set_vec[SRC_RTO]   = rto_evt;
    set_vec[SRC_FRM]   = rx_push && rx_push_err[0];
    set_vec[SRC_PAR]   = rx_push && rx_push_err[1];
    set_vec[SRC_BRK]   = rx_push && rx_push_err[2];
    set_vec[SRC_OVR]   = ovr_evt;
    set_vec[SRC_CTS]   = cts_evt;
    clr_vec            = wr_iclr ? reg_wdata[NUM_SRC-1:0] : '0;
  end

  uart_irq_stat #(.N(NUM_SRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask_we(wr_mask), .mask_wdata(reg_wdata[NUM_SRC-1:0]),
    .raw(raw_stat), .masked(mask_stat), .irq(irq)
  );

  // R3
  rx_lvl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_stat[SRC_RXLVL]) |-> $past(rx_lvl_evt));
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  localparam int DEPTH = 32;
  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] rx_count = '0, tx_count = '0;
  logic             rx_push = 0, rx_pop = 0, rto_evt = 0, cts_evt = 0, reg_we = 0;
  logic [2:0]       rx_push_err = '0, rx_pop_err = '0;
  logic [1:0]       reg_sel = '0;
  logic [7:0]       reg_wdata = '0;
  logic [7:0]       raw_stat, mask_stat;
  logic             irq;
  logic [3:0]       err_stat;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [7:0] m_raw, m_mask;
  logic [3:0] m_err;
  logic [5:0] m_level;
  logic       m_rxq, m_txq;

  always #10 clk = ~clk;

  uart_irq_ctrl #(.DEPTH(DEPTH)) i_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .rx_push(rx_push), .rx_push_err(rx_push_err), .rx_pop(rx_pop), .rx_pop_err(rx_pop_err),
    .rto_evt(rto_evt), .cts_evt(cts_evt), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .raw_stat(raw_stat), .mask_stat(mask_stat), .irq(irq),
    .err_stat(err_stat)
  );

  function automatic int thr_of(input logic [2:0] code);
    case (code)
      3'd0: return 4;
      3'd1: return 8;
      3'd2: return 16;
      3'd3: return 24;
      3'd4: return 28;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_raw = '0; m_mask = '0; m_err = '0; m_level = {3'd2, 3'd2}; m_rxq = 0; m_txq = 1;
  endtask

  task automatic model_step();
    logic rxc, txc, ovr;
    logic [7:0] set, clr;
    rxc = int'(rx_count) >= thr_of(m_level[5:3]);
    txc = int'(tx_count) <= thr_of(m_level[2:0]);
    ovr = rx_push && (int'(rx_count) == DEPTH);
    set = {cts_evt, ovr, rx_push ? rx_push_err : 3'b000, rto_evt, txc && !m_txq, rxc && !m_rxq};
    clr = (reg_we && reg_sel == 2'd2) ? reg_wdata : 8'h00;
    m_raw = (m_raw & ~clr) | set;
    if (reg_we && reg_sel == 2'd3) m_err = '0;
    if (rx_pop) m_err[2:0] = rx_pop_err;
    if (ovr) m_err[3] = 1'b1;
    if (reg_we && reg_sel == 2'd0) m_level = reg_wdata[5:0];
    if (reg_we && reg_sel == 2'd1) m_mask = reg_wdata;
    m_rxq = rxc; m_txq = txc;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    rx_push = 0; rx_pop = 0; rto_evt = 0; cts_evt = 0; reg_we = 0;
    rx_push_err = '0; rx_pop_err = '0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 raw", raw_stat, 8'h00);
    chk("R1 err", {4'h0, err_stat}, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rst_n = 1;
    tick();
    chk("R4 no event for empty queue at reset", raw_stat, 8'h00);

    wr(2'd0, 8'h04);            // rx code 0 (4), tx code 4 (28)
    tick();
    rx_count = 3; tick();
    chk("R2 rx below thr", {7'b0, raw_stat[0]}, 8'h00);
    rx_count = 4; tick();
    chk("R3 rx level reached", {7'b0, raw_stat[0]}, 8'h01);
    tx_count = 30; tick();
    chk("R2 tx above thr", {7'b0, raw_stat[1]}, 8'h00);
    tx_count = 28; tick();
    chk("R4 tx level reached", {7'b0, raw_stat[1]}, 8'h01);
    rx_count = 0; tick();
    chk("R5 level bit sticky", {7'b0, raw_stat[0]}, 8'h01);

    wr(2'd2, 8'h01); tick();
    chk("R10 clear bit0 only", raw_stat, 8'h02);

    wr(2'd1, 8'h02); tick();
    chk("R11 masked", mask_stat, 8'h02);
    chk("R11 irq on", {7'b0, irq}, 8'h01);
    wr(2'd1, 8'h01); tick();
    chk("R11 irq off", {7'b0, irq}, 8'h00);

    rx_count = 32; rx_push = 1; tick();
    chk("R7 overrun raw", {7'b0, raw_stat[6]}, 8'h01);
    chk("R7 overrun err", {4'h0, err_stat}, 8'h08);
    wr(2'd3, 8'h00); tick();
    chk("R9 err cleared", {4'h0, err_stat}, 8'h00);
    chk("R9 raw kept", {7'b0, raw_stat[6]}, 8'h01);

    rx_pop = 1; rx_pop_err = 3'b101; tick();
    chk("R8 err from read char", {4'h0, err_stat}, 8'h05);
    rx_pop = 1; rx_pop_err = 3'b000; tick();
    chk("R8 err replaced", {4'h0, err_stat}, 8'h00);

    rx_count = 5; rx_push = 1; rx_push_err = 3'b010; tick();
    chk("R6 parity raw", {6'b0, raw_stat[4:3]}, 8'h02);
    rto_evt = 1; tick();
    chk("R6 timeout raw", {7'b0, raw_stat[2]}, 8'h01);
    cts_evt = 1; wr(2'd2, 8'h80); tick();
    chk("R10 event wins over clear", {7'b0, raw_stat[7]}, 8'h01);

    rx_count = 15; wr(2'd0, 8'h28); tick();  // rx code 5 -> 16
    wr(2'd2, 8'hFF); tick();
    chk("R10 clear all", raw_stat, 8'h00);
    rx_count = 16; tick();
    chk("R2 reserved code half", {7'b0, raw_stat[0]}, 8'h01);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) rx_count = CNT_W'($urandom_range(DEPTH));
      if ($urandom_range(3) == 0) tx_count = CNT_W'($urandom_range(DEPTH));
      rx_push     = ($urandom_range(3) == 0);
      rx_push_err = 3'($urandom_range(7));
      rx_pop      = ($urandom_range(3) == 0);
      rx_pop_err  = 3'($urandom_range(7));
      rto_evt     = ($urandom_range(15) == 0);
      cts_evt     = ($urandom_range(15) == 0);
      if ($urandom_range(3) == 0) wr(2'($urandom_range(3)), 8'($urandom_range(255)));
      tick();
      chk("R10 random raw", raw_stat, m_raw);
      chk("R11 random masked", mask_stat, m_raw & m_mask);
      chk("R11 random irq", {7'b0, irq}, {7'b0, |(m_raw & m_mask)});
      chk("R8 random err", {4'h0, err_stat}, {4'h0, m_err});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule